// File: doc/BRIEF.md
# Bit-Serial I2C Port

This peripheral gives a small processor direct access to an I2C bus one bit at a time. Software talks to it through a two-address register port: a control address and a data address. Every rising edge of SCL captures SDA into a received-bit register and raises a data-ready flag. Start and stop conditions seen on the bus raise their own flags. A loss of arbitration while sending a 1 raises a further flag. Any raised flag drives the attention output. The control address reads as a flag word. It writes as a set of write-one-to-clear and command bits, so the meaning of each bit differs between read and write.

Both bus pins are open-drain: the block only ever pulls a line low, through `scl_oe` and `sda_oe`. The bus inputs pass through a two-flop synchronizer before any edge or condition is judged. A master sequencer can issue a start (or repeated start), clock data bits and issue a stop. While it is master, and while it is a slave with an unread bit, the block stretches SCL low until software services the data-ready flag. An idle mode lets a slave ignore the bus until the next start condition.

The sequencer has nine named states. In SLAVE the block listens and stretches the clock. The start sequence runs RS_SDA_UP (SDA released, SCL held low), then RS_SCL_UP (SCL released and seen high), then RS_SDA_DN (SDA pulled low while SCL is high), and goes on to CLK_LOW. CLK_LOW holds SCL low. It moves to CLK_HIGH once its half-period has run and data-ready is clear. CLK_HIGH releases SCL and returns to CLK_LOW one half-period after SCL is seen high. A stop command leaves CLK_LOW or CLK_HIGH through SP_SDA_DN, then SP_SCL_UP, then SP_SDA_UP, and ends in SLAVE. A repeated-start command leaves SLAVE, CLK_LOW or CLK_HIGH for RS_SDA_UP. Arbitration loss returns CLK_LOW or CLK_HIGH straight to SLAVE.

Top module: `i2c_bit_port`

## Requirements
- R1: After reset the control register reads 81h, the attention output is 0 and neither bus pin is pulled low.
- R2: A control read returns {received bit, attention, data-ready, arbitration-lost, start-seen, stop-seen, master, 1} from bit 7 down to bit 0. Attention (bit 6 and the `attn` port) is the OR of bits 5 to 2.
- R3: On each synchronized rising SCL edge, while the block is listening (master, or slave not idle), data-ready is set and SDA is captured as the received bit.
- R4: A data read returns the received bit in bit 7 with bits 6 to 0 zero. It clears data-ready and transmit-active.
- R5: A data write takes bit 7 as the bit to send, clears data-ready and sets transmit-active. While transmit-active is set, SDA is pulled low for a 0 and released for a 1.
- R6: Control write bits 7, 5, 4, 3 and 2 clear transmit-active, data-ready, arbitration-lost, start-seen and stop-seen respectively, each only when written as 1. Zeros have no effect.
- R7: SDA falling while SCL is high sets start-seen. SDA rising while SCL is high sets stop-seen. Both are set only while the block is listening.
- R8: Writing 1 to control bit 6 as slave enters idle mode. In idle mode SCL edges and stop conditions change no flag. The next start condition leaves idle mode without setting start-seen.
- R9: As slave, with data-ready set and SCL low, the block pulls SCL low until data-ready is cleared.
- R10: Writing 1 to control bit 1 runs the start sequence. The master bit reads 1 from the next cycle, and the start is then seen on the bus.
- R11: Writing 1 to control bit 0 as master runs the stop sequence, after which master is 0 and both pins are released. As slave the write has no effect.
- R12: As transmitter, sampling SDA low at a rising SCL edge while sending a 1 sets arbitration-lost, clears transmit-active and drops master status.
- R13: As master, the block holds SCL low while data-ready is set and clocks the next bit only after it is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | 0 selects control, 1 selects data |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects on data reads) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| attn | output | 1 | Any flag raised |

## Verification
On every cycle the assertions check several links. Each new data-ready follows a detected SCL rise, and each new start flag follows a detected start. Arbitration loss only follows a 1 being transmitted. Master status only ends from the last stop state or an arbitration loss. The slave stretch and idle-mode silence on SCL are also checked each cycle. Only the directed scenarios can show the exact flag words after full bus sequences, the received bit values, and the clear-on-write behaviour at the register port. The same applies to the master sequencing driving real start and stop conditions onto a modelled wired-AND bus.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

    typedef enum logic [3:0] {
        ST_SLAVE,
        ST_RS_SDA_UP,
        ST_RS_SCL_UP,
        ST_RS_SDA_DN,
        ST_CLK_LOW,
        ST_CLK_HIGH,
        ST_SP_SDA_DN,
        ST_SP_SCL_UP,
        ST_SP_SDA_UP
    } mst_state_t;

    // control write bit positions (software-visible, fixed)
    localparam int CW_TXCLR  = 7;
    localparam int CW_IDLE   = 6;
    localparam int CW_DRDY   = 5;
    localparam int CW_ARL    = 4;
    localparam int CW_STR    = 3;
    localparam int CW_STP    = 2;
    localparam int CW_RSTART = 1;
    localparam int CW_STOP   = 0;

    localparam int DATA_BIT  = 7;

    function automatic logic in_sequence(input mst_state_t s);
        return !(s == ST_SLAVE || s == ST_CLK_LOW || s == ST_CLK_HIGH);
    endfunction

endpackage

// File: rtl/i2cb_pin_sync.sv
module i2cb_pin_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], d[i]};
        end
        assign q[i] = chain[STAGES-1];
    end
endmodule

// File: rtl/i2cb_bus_watch.sv
module i2cb_bus_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_d;
    assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2cb_flags.sv
module i2cb_flags
    import i2cb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic       data_wr,
    input  logic       data_rd,
    input  logic [7:0] wdata,
    input  logic       scl_rise,
    input  logic       sda_s,
    input  logic       start_ev,
    input  logic       stop_ev,
    input  logic       is_master,
    input  logic       seq_busy,
    output logic       rdat,
    output logic       drdy,
    output logic       arl,
    output logic       str,
    output logic       stp,
    output logic       tx_active,
    output logic       tx_bit,
    output logic       ignore,
    output logic       arl_evt
);
    logic listening;

    assign listening = is_master | ~ignore;
    assign arl_evt   = scl_rise & listening & tx_active & tx_bit & ~sda_s & ~seq_busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdat      <= 1'b1;
            drdy      <= 1'b0;
            arl       <= 1'b0;
            str       <= 1'b0;
            stp       <= 1'b0;
            tx_active <= 1'b0;
            tx_bit    <= 1'b1;
            ignore    <= 1'b0;
        end else begin
            // received bit and data-ready: a new edge wins over a clear
            if (scl_rise && listening) begin
                rdat <= sda_s;
                drdy <= 1'b1;
            end else if (data_wr || data_rd || (ctrl_wr && wdata[CW_DRDY])) begin
                drdy <= 1'b0;
            end

            if (arl_evt)                          arl <= 1'b1;
            else if (ctrl_wr && wdata[CW_ARL])    arl <= 1'b0;

            if (start_ev && listening)            str <= 1'b1;
            else if (ctrl_wr && wdata[CW_STR])    str <= 1'b0;

            if (stop_ev && listening)             stp <= 1'b1;
            else if (ctrl_wr && wdata[CW_STP])    stp <= 1'b0;

            // transmit state: loss of arbitration overrides a new bit
            if (arl_evt)                                      tx_active <= 1'b0;
            else if (data_wr)                                 tx_active <= 1'b1;
            else if (data_rd || (ctrl_wr && wdata[CW_TXCLR])) tx_active <= 1'b0;

            if (data_wr) tx_bit <= wdata[DATA_BIT];

            if (ctrl_wr && wdata[CW_IDLE] && !is_master) ignore <= 1'b1;
            else if (start_ev)                           ignore <= 1'b0;
        end
    end
endmodule

// File: rtl/i2cb_master_fsm.sv
module i2cb_master_fsm
    import i2cb_pkg::*;
#(
    parameter int HALF = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_rstart,
    input  logic       cmd_stop,
    input  logic       scl_s,
    input  logic       drdy,
    input  logic       ignore,
    input  logic       arl_evt,
    output mst_state_t st,
    output logic       is_master,
    output logic       seq_busy,
    output logic       scl_low,
    output logic       sda_force_low,
    output logic       sda_force_rel
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    mst_state_t    st_nx;
    logic [CW-1:0] cnt;
    logic          wait_high, cnt_en, tick;

    assign wait_high = (st == ST_RS_SCL_UP) || (st == ST_CLK_HIGH) || (st == ST_SP_SCL_UP);
    assign cnt_en    = wait_high ? scl_s : 1'b1;
    assign tick      = cnt_en && (cnt == LAST);

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_SLAVE:     if (cmd_rstart) st_nx = ST_RS_SDA_UP;
            ST_RS_SDA_UP: if (tick) st_nx = ST_RS_SCL_UP;
            ST_RS_SCL_UP: if (tick) st_nx = ST_RS_SDA_DN;
            ST_RS_SDA_DN: if (tick) st_nx = ST_CLK_LOW;
            ST_CLK_LOW: begin
                if (arl_evt)             st_nx = ST_SLAVE;
                else if (cmd_stop)       st_nx = ST_SP_SDA_DN;
                else if (cmd_rstart)     st_nx = ST_RS_SDA_UP;
                else if (tick && !drdy)  st_nx = ST_CLK_HIGH;
            end
            ST_CLK_HIGH: begin
                if (arl_evt)             st_nx = ST_SLAVE;
                else if (cmd_stop)       st_nx = ST_SP_SDA_DN;
                else if (cmd_rstart)     st_nx = ST_RS_SDA_UP;
                else if (tick)           st_nx = ST_CLK_LOW;
            end
            ST_SP_SDA_DN: if (tick) st_nx = ST_SP_SCL_UP;
            ST_SP_SCL_UP: if (tick) st_nx = ST_SP_SDA_UP;
            ST_SP_SDA_UP: if (tick) st_nx = ST_SLAVE;
            default:      st_nx = ST_SLAVE;
        endcase
    end

    // state register and half-period counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_SLAVE;
            cnt <= '0;
        end else begin
            st <= st_nx;
            if (st_nx != st)               cnt <= '0;
            else if (cnt_en && cnt != LAST) cnt <= cnt + 1'b1;
        end
    end

    // outputs
    always_comb begin
        is_master     = (st != ST_SLAVE);
        seq_busy      = in_sequence(st);
        scl_low       = 1'b0;
        sda_force_low = 1'b0;
        sda_force_rel = 1'b0;
        unique case (st)
            ST_SLAVE:     scl_low = drdy & ~scl_s & ~ignore;
            ST_RS_SDA_UP: begin scl_low = 1'b1; sda_force_rel = 1'b1; end
            ST_RS_SCL_UP: sda_force_rel = 1'b1;
            ST_RS_SDA_DN: sda_force_low = 1'b1;
            ST_CLK_LOW:   scl_low = 1'b1;
            ST_CLK_HIGH:  scl_low = 1'b0;
            ST_SP_SDA_DN: begin scl_low = 1'b1; sda_force_low = 1'b1; end
            ST_SP_SCL_UP: sda_force_low = 1'b1;
            ST_SP_SDA_UP: sda_force_rel = 1'b1;
            default:      scl_low = 1'b0;
        endcase
    end
endmodule

// File: rtl/i2c_bit_port.sv
module i2c_bit_port
    import i2cb_pkg::*;
#(
    parameter int HALF        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_sel,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       attn
);
    logic [1:0] pins_s;
    logic       scl_s, sda_s;
    logic       scl_rise, start_ev, stop_ev;
    logic       ctrl_wr, data_wr, data_rd;
    logic       rdat, drdy, arl, str, stp, tx_active, tx_bit, ignore, arl_evt;
    logic       is_master, seq_busy, scl_low, sda_force_low, sda_force_rel;
    mst_state_t st;

    assign ctrl_wr = wr_en & ~reg_sel;
    assign data_wr = wr_en & reg_sel;
    assign data_rd = rd_en & reg_sel;

    i2cb_pin_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(pins_s)
    );
    assign scl_s = pins_s[1];
    assign sda_s = pins_s[0];

    i2cb_bus_watch u_watch (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .start_ev(start_ev), .stop_ev(stop_ev)
    );

    i2cb_flags u_flags (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .data_wr(data_wr),
        .data_rd(data_rd), .wdata(wdata), .scl_rise(scl_rise), .sda_s(sda_s),
        .start_ev(start_ev), .stop_ev(stop_ev), .is_master(is_master),
        .seq_busy(seq_busy), .rdat(rdat), .drdy(drdy), .arl(arl), .str(str),
        .stp(stp), .tx_active(tx_active), .tx_bit(tx_bit), .ignore(ignore),
        .arl_evt(arl_evt)
    );

    i2cb_master_fsm #(.HALF(HALF)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cmd_rstart(ctrl_wr & wdata[CW_RSTART]),
        .cmd_stop(ctrl_wr & wdata[CW_STOP]),
        .scl_s(scl_s), .drdy(drdy), .ignore(ignore), .arl_evt(arl_evt),
        .st(st), .is_master(is_master), .seq_busy(seq_busy),
        .scl_low(scl_low), .sda_force_low(sda_force_low),
        .sda_force_rel(sda_force_rel)
    );

    assign attn   = drdy | arl | str | stp;
    assign scl_oe = scl_low;
    assign sda_oe = sda_force_low | (~sda_force_rel & tx_active & ~tx_bit);

    assign rdata = reg_sel ? {rdat, 7'b0}
                           : {rdat, attn, drdy, arl, str, stp, is_master, 1'b1};
endmodule

// File: rtl/i2cb_checker.sv
module i2cb_checker
    import i2cb_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input mst_state_t st,
    input logic       drdy,
    input logic       scl_s,
    input logic       ignore,
    input logic       scl_oe,
    input logic       is_master,
    input logic       arl_evt,
    input logic       arl,
    input logic       tx_active,
    input logic       tx_bit,
    input logic       scl_rise,
    input logic       str,
    input logic       start_ev
);
    // R3
    drdy_from_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drdy) |-> $past(scl_rise));

    // R7
    str_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(str) |-> $past(start_ev));

    // R12
    arl_needs_tx_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arl) |-> ($past(tx_active) && $past(tx_bit)));

    // R11
    master_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(is_master) |-> ($past(st) == ST_SP_SDA_UP || $past(arl_evt)));

    // R9
    slave_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SLAVE && drdy && !scl_s && !ignore) |-> scl_oe);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SLAVE && ignore) |-> !scl_oe);
endmodule

bind i2c_bit_port i2cb_checker u_chk (
    .clk(clk), .rst_n(rst_n), .st(st), .drdy(drdy), .scl_s(scl_s),
    .ignore(ignore), .scl_oe(scl_oe), .is_master(is_master),
    .arl_evt(arl_evt), .arl(arl), .tx_active(tx_active), .tx_bit(tx_bit),
    .scl_rise(scl_rise), .str(str), .start_ev(start_ev)
);

// File: tb/sim_i2c_bit_port.sv
`timescale 1ns/1ps
module sim_i2c_bit_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       scl_oe, sda_oe, attn;
    logic       scl_drv = 1'b1;
    logic       sda_drv = 1'b1;
    logic       scl_line, sda_line;
    int         total = 0;
    int         bad = 0;

    always #2 clk = ~clk;

    assign scl_line = scl_drv & ~scl_oe;
    assign sda_line = sda_drv & ~sda_oe;

    i2c_bit_port u0 (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .scl_in(scl_line),
        .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe), .attn(attn)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = 8'h00;
    endtask

    task automatic rd(input logic sel, output logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic scl(input logic v); scl_drv = v; cyc(8); endtask
    task automatic sda(input logic v); sda_drv = v; cyc(8); endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(1'b0, v);
        chk("R1 ctrl after reset", v, 8'h81);
        chk("R1 attn", {7'b0, attn}, 8'h00);
        chk("R1 pins released", {6'b0, scl_oe, sda_oe}, 8'h00);
    endtask

    task automatic t_conditions();
        logic [7:0] v;
        sda(1'b0);
        rd(1'b0, v); chk("R7 start sets flag, R2 layout", v, 8'hC9);
        sda(1'b1);
        rd(1'b0, v); chk("R7 stop sets flag", v, 8'hCD);
        wr(1'b0, 8'h00);
        rd(1'b0, v); chk("R6 zero write no effect", v, 8'hCD);
        wr(1'b0, 8'h08);
        rd(1'b0, v); chk("R6 clear start flag", v, 8'hC5);
        wr(1'b0, 8'h04);
        rd(1'b0, v); chk("R6 clear stop flag", v, 8'h81);
        chk("R2 attn port low", {7'b0, attn}, 8'h00);
    endtask

    task automatic t_receive();
        logic [7:0] v;
        scl(1'b0); sda(1'b0); scl(1'b1);
        rd(1'b0, v); chk("R3 rise captures 0", v, 8'h61);
        chk("R2 attn port high", {7'b0, attn}, 8'h01);
        scl(1'b0);
        chk("R9 slave stretch", {7'b0, scl_oe}, 8'h01);
        rd(1'b1, v); chk("R4 data read", v, 8'h00);
        cyc(1);
        chk("R9 stretch released", {7'b0, scl_oe}, 8'h00);
        rd(1'b0, v); chk("R4 drdy cleared", v, 8'h01);
        sda(1'b1); scl(1'b1);
        rd(1'b0, v); chk("R3 rise captures 1", v, 8'hE1);
        rd(1'b1, v); chk("R4 data read 1", v, 8'h80);
    endtask

    task automatic t_transmit();
        logic [7:0] v;
        scl(1'b0);
        wr(1'b1, 8'h00); cyc(2);
        chk("R5 send 0 pulls SDA", {7'b0, sda_oe}, 8'h01);
        wr(1'b0, 8'h80); cyc(2);
        chk("R6 clear tx releases SDA", {7'b0, sda_oe}, 8'h00);
        wr(1'b1, 8'h00); cyc(2);
        chk("R5 send 0 again", {7'b0, sda_oe}, 8'h01);
        rd(1'b1, v); cyc(1);
        chk("R4 read clears tx", {7'b0, sda_oe}, 8'h00);
        wr(1'b1, 8'h80); cyc(2);
        chk("R5 send 1 releases SDA", {7'b0, sda_oe}, 8'h00);
        wr(1'b0, 8'h80);
        scl(1'b1);
        rd(1'b1, v);
        rd(1'b0, v); chk("R5 slave clean", v, 8'h81);
    endtask

    task automatic t_idle();
        logic [7:0] v;
        wr(1'b0, 8'h40);
        scl(1'b0); scl(1'b1);
        rd(1'b0, v); chk("R8 idle ignores SCL", v & 8'h7E, 8'h00);
        scl(1'b0); sda(1'b0); scl(1'b1); sda(1'b1);
        rd(1'b0, v); chk("R8 idle ignores stop", v & 8'h7E, 8'h00);
        sda(1'b0);
        rd(1'b0, v); chk("R8 waking start no flag", v & 8'h7E, 8'h00);
        scl(1'b0); sda(1'b1); scl(1'b1);
        rd(1'b0, v); chk("R8 listening after wake", v, 8'hE1);
        scl(1'b0);
        chk("R9 stretch after wake", {7'b0, scl_oe}, 8'h01);
        scl_drv = 1'b1;
        rd(1'b1, v); chk("R4 read during stretch", v, 8'h80);
        cyc(1);
        chk("R9 stretch ends", {7'b0, scl_oe}, 8'h00);
        cyc(10);
        rd(1'b1, v);
        wr(1'b0, 8'h3C);
    endtask

    task automatic t_stop_as_slave();
        logic [7:0] v;
        wr(1'b0, 8'h01); cyc(20);
        chk("R11 stop ignored as slave", {6'b0, scl_oe, sda_oe}, 8'h00);
        rd(1'b0, v); chk("R11 still slave", v, 8'h81);
    endtask

    task automatic t_master();
        logic [7:0] v;
        wr(1'b0, 8'h02); cyc(1);
        rd(1'b0, v); chk("R10 master bit", v & 8'h02, 8'h02);
        cyc(40);
        rd(1'b0, v); chk("R10 start seen as master", v, 8'hEB);
        cyc(20);
        chk("R13 SCL held while drdy", {7'b0, scl_oe}, 8'h01);
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h08);
        cyc(40);
        rd(1'b0, v); chk("R13 bit clocked", v, 8'h63);
        chk("R5 master sends 0", {6'b0, scl_oe, sda_oe}, 8'h03);
        wr(1'b0, 8'h80); cyc(4);
        wr(1'b0, 8'h01); cyc(40);
        rd(1'b0, v); chk("R11 stop as master", v, 8'h65);
        chk("R11 pins released", {6'b0, scl_oe, sda_oe}, 8'h00);
        rd(1'b1, v); chk("R4 data after stop", v, 8'h00);
        rd(1'b0, v); chk("R4 drdy cleared", v, 8'h45);
        wr(1'b0, 8'h3C);
    endtask

    task automatic t_arbitration();
        logic [7:0] v;
        wr(1'b0, 8'h02); cyc(40);
        sda_drv = 1'b0;
        wr(1'b1, 8'h80); cyc(40);
        rd(1'b0, v); chk("R12 arbitration lost", v, 8'h79);
        chk("R12 pins released", {6'b0, scl_oe, sda_oe}, 8'h00);
        sda(1'b1);
        rd(1'b1, v);
        wr(1'b0, 8'h3C);
        rd(1'b0, v); chk("R12 clean", v & 8'h7E, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cyc(4);
        rst_n = 1'b1;
        cyc(4);
        t_reset();
        t_conditions();
        t_receive();
        t_transmit();
        t_idle();
        t_stop_as_slave();
        t_master();
        t_arbitration();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule